// File: doc/BRIEF.md
# Four-Slot ROM Bank Mapper

This block turns a 24-bit processor address into a byte offset within an external ROM. The 16 MB processor space is split into four 1 MB slots, each with a 3-bit bank register and a remap flag. Two address views share those slot registers:

- **Paged view.** It maps 32 KB pages seen in the upper half of banks in the low quarters of the map. When a slot's remap flag is clear, the slot keeps its fixed default placement. When the flag is set, the slot follows its bank register.
- **Linear view.** It covers whole 64 KB banks at the top of the map and always follows the bank registers.

Two interrupt-vector words can be replaced by register values. When a replacement is enabled, reads of those vector bytes come from the replacement path and not from ROM. The resulting physical offset is folded into the installed ROM size, which is a power of two.

The mapping is combinational from the address, followed by one register stage, so every result appears one clock after its address. The ROM array itself sits outside the block. The consumer uses `rom_sel` to pick between ROM data at `rom_addr` and the byte on `ovr_data`.

Top module: `rom_slot_mapper`

## Requirements
- R1: In the paged view (address bit 22 clear, bit 15 set), the slot index is {addr[23], addr[21]}. Banks 00-1F use slot 0, 20-3F slot 1, 80-9F slot 2 and A0-BF slot 3. The offset within the slot is {addr[20:16], addr[14:0]}. With the slot's remap flag clear, the physical base is slot index × 1 MB.
- R2: In the paged view with the slot's remap flag set, the physical base is the slot's bank register × 1 MB. The bank register of slot i is `slot_bank[3i+2:3i]`, and the remap flag of slot i is `slot_remap[i]`.
- R3: Banks C0-FF use slot addr[21:20]. The physical address is that slot's bank register × 1 MB plus addr[19:0], and the remap flag has no effect.
- R4: While `nmi_swap_en` is 1, address 0x00FFEA yields `rom_sel`=0 with `ovr_data`=`nmi_vec[7:0]`, and 0x00FFEB yields `nmi_vec[15:8]`. While it is 0, both addresses read ROM as in R1.
- R5: While `irq_swap_en` is 1, address 0x00FFEE yields `rom_sel`=0 with `ovr_data`=`irq_vec[7:0]`, and 0x00FFEF yields `irq_vec[15:8]`. While it is 0, both addresses read ROM.
- R6: The physical address is masked with 2^`rom_size_lg` − 1. Values of 23 or more leave all 23 bits.
- R7: An address in neither view (bank 40-7F, or bank 00-3F/80-BF with addr[15]=0) gives `rom_sel`=0, `rom_addr`=0 and `ovr_data`=0x00.
- R8: Outputs are registered: the result for an address applied before a rising edge appears after that edge. In reset all outputs are 0. Whenever `rom_sel` is 1, `ovr_data` is 0x00.
- R9: Replacement applies only to the four exact vector addresses in bank 00. 0x00FFEC, 0x01FFEA and 0x80FFEA read ROM even with both replacements enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_addr | input | 24 | Processor address |
| slot_bank | input | 12 | Four 3-bit bank registers, slot i at bits 3i+2:3i |
| slot_remap | input | 4 | Remap flag per slot for the paged view |
| nmi_swap_en | input | 1 | Enable replacement of the NMI vector bytes |
| nmi_vec | input | 16 | Replacement NMI vector |
| irq_swap_en | input | 1 | Enable replacement of the IRQ vector bytes |
| irq_vec | input | 16 | Replacement IRQ vector |
| rom_size_lg | input | 5 | log2 of the installed ROM size in bytes |
| rom_sel | output | 1 | 1: read ROM at rom_addr; 0: use ovr_data |
| rom_addr | output | 23 | Physical ROM byte offset |
| ovr_data | output | 8 | Replacement vector byte, or 0x00 when unmapped |

## Verification
The hardest case to reach is a paged-view vector address whose replacement is switched off or which sits one byte or one bank away from an exact match. In that case the address must fall through to an ordinary ROM lookup that itself depends on the slot 0 remap flag and on mirroring. The stimulus drives each vector address in turn with its enable on and then off, and does so under both remap settings of slot 0. It also probes 0x00FFEC and the same offset in banks 01 and 80. A reduced ROM size is applied during linear-view accesses whose bank registers point above the installed size, so that the fold is visible in the high bits.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int NSLOT    = 4;
  localparam int SLOT_IDX_W = 2;
  localparam int SPAN_W   = 20;  // 1 MB per slot
  localparam int CPU_AW   = 24;

  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_PAGED  = 2'd1,
    RGN_LINEAR = 2'd2
  } region_e;

  function automatic logic [31:0] size_mask(input logic [5:0] lg);
    if (lg >= 6'd32) return 32'hFFFF_FFFF;
    return (32'd1 << lg) - 32'd1;
  endfunction
endpackage

// File: rtl/rsm_region_decode.sv
module rsm_region_decode
  import rsm_pkg::*;
(
  input  logic [CPU_AW-1:0]     addr,
  output region_e               region,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic [SPAN_W-1:0]     slot_off
);
  always_comb begin
    region   = RGN_NONE;
    slot_idx = '0;
    slot_off = '0;
    if (!addr[22] && addr[15]) begin
      region   = RGN_PAGED;
      slot_idx = {addr[23], addr[21]};
      slot_off = {addr[20:16], addr[14:0]};
    end else if (addr[23:22] == 2'b11) begin
      region   = RGN_LINEAR;
      slot_idx = addr[21:20];
      slot_off = addr[19:0];
    end
  end
endmodule

// File: rtl/rsm_slot_base.sv
module rsm_slot_base
  import rsm_pkg::*;
#(
  parameter int SLOT_BANK_W = 3
) (
  input  logic [NSLOT*SLOT_BANK_W-1:0] slot_bank,
  input  logic [NSLOT-1:0]             slot_remap,
  input  logic [SLOT_IDX_W-1:0]        slot_idx,
  input  logic                         linear,
  output logic [SLOT_BANK_W-1:0]       base
);
  logic [SLOT_BANK_W-1:0] paged_base  [NSLOT];
  logic [SLOT_BANK_W-1:0] linear_base [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign linear_base[i] = slot_bank[i*SLOT_BANK_W +: SLOT_BANK_W];
    assign paged_base[i]  = slot_remap[i] ? linear_base[i] : SLOT_BANK_W'(i);
  end

  always_comb begin
    if (linear) base = linear_base[slot_idx];
    else        base = paged_base[slot_idx];
  end
endmodule

// File: rtl/rsm_vector_sub.sv
module rsm_vector_sub
  import rsm_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  input  logic              nmi_en,
  input  logic [15:0]       nmi_vec,
  input  logic              irq_en,
  input  logic [15:0]       irq_vec,
  output logic              hit,
  output logic [7:0]        byte_out
);
  always_comb begin
    hit      = 1'b0;
    byte_out = 8'h00;
    if (addr[23:4] == 20'h00FFE) begin
      unique case (addr[3:0])
        4'hA: begin hit = nmi_en; byte_out = nmi_vec[7:0];  end
        4'hB: begin hit = nmi_en; byte_out = nmi_vec[15:8]; end
        4'hE: begin hit = irq_en; byte_out = irq_vec[7:0];  end
        4'hF: begin hit = irq_en; byte_out = irq_vec[15:8]; end
        default: begin hit = 1'b0; byte_out = 8'h00; end
      endcase
    end
  end
endmodule

// File: rtl/rom_slot_mapper.sv
module rom_slot_mapper
  import rsm_pkg::*;
#(
  parameter int SLOT_BANK_W = 3,
  localparam int ROM_AW = SLOT_BANK_W + SPAN_W,
  localparam int SIZE_W = $clog2(ROM_AW + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CPU_AW-1:0]            cpu_addr,
  input  logic [NSLOT*SLOT_BANK_W-1:0] slot_bank,
  input  logic [NSLOT-1:0]             slot_remap,
  input  logic                         nmi_swap_en,
  input  logic [15:0]                  nmi_vec,
  input  logic                         irq_swap_en,
  input  logic [15:0]                  irq_vec,
  input  logic [SIZE_W-1:0]            rom_size_lg,
  output logic                         rom_sel,
  output logic [ROM_AW-1:0]            rom_addr,
  output logic [7:0]                   ovr_data
);
  region_e               region;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [SPAN_W-1:0]     slot_off;
  logic [SLOT_BANK_W-1:0] base;
  logic                  vec_hit;
  logic [7:0]            vec_byte;
  logic [ROM_AW-1:0]     size_msk;

  logic                  sel_d;
  logic [ROM_AW-1:0]     addr_d;
  logic [7:0]            data_d;

  rsm_region_decode u_dec (
    .addr     (cpu_addr),
    .region   (region),
    .slot_idx (slot_idx),
    .slot_off (slot_off)
  );

  rsm_slot_base #(.SLOT_BANK_W(SLOT_BANK_W)) u_base (
    .slot_bank  (slot_bank),
    .slot_remap (slot_remap),
    .slot_idx   (slot_idx),
    .linear     (region == RGN_LINEAR),
    .base       (base)
  );

  rsm_vector_sub u_vec (
    .addr     (cpu_addr),
    .nmi_en   (nmi_swap_en),
    .nmi_vec  (nmi_vec),
    .irq_en   (irq_swap_en),
    .irq_vec  (irq_vec),
    .hit      (vec_hit),
    .byte_out (vec_byte)
  );

  assign size_msk = ROM_AW'(size_mask(6'(rom_size_lg)));

  // next-state
  always_comb begin
    sel_d  = 1'b0;
    addr_d = '0;
    data_d = 8'h00;
    if (vec_hit) begin
      data_d = vec_byte;
    end else if (region != RGN_NONE) begin
      sel_d  = 1'b1;
      addr_d = {base, slot_off} & size_msk;
    end
  end

  // register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_sel  <= 1'b0;
      rom_addr <= '0;
      ovr_data <= 8'h00;
    end else begin
      rom_sel  <= sel_d;
      rom_addr <= addr_d;
      ovr_data <= data_d;
    end
  end
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker
  import rsm_pkg::*;
#(
  parameter int SLOT_BANK_W = 3,
  localparam int ROM_AW = SLOT_BANK_W + SPAN_W,
  localparam int SIZE_W = $clog2(ROM_AW + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [CPU_AW-1:0]            cpu_addr,
  input logic [NSLOT*SLOT_BANK_W-1:0] slot_bank,
  input logic [NSLOT-1:0]             slot_remap,
  input logic                         nmi_swap_en,
  input logic [15:0]                  nmi_vec,
  input logic                         irq_swap_en,
  input logic [15:0]                  irq_vec,
  input logic [SIZE_W-1:0]            rom_size_lg,
  input logic                         rom_sel,
  input logic [ROM_AW-1:0]            rom_addr,
  input logic [7:0]                   ovr_data
);
  logic unmapped_in;
  logic remapped_paged_in;
  logic [SLOT_IDX_W-1:0] pg_slot;

  assign unmapped_in = (cpu_addr[23:22] == 2'b01) || (!cpu_addr[22] && !cpu_addr[15]);
  assign pg_slot = {cpu_addr[23], cpu_addr[21]};
  assign remapped_paged_in = !cpu_addr[22] && cpu_addr[15] && (cpu_addr[15:4] != 12'hFFE)
                             && slot_remap[pg_slot] && (32'(rom_size_lg) >= ROM_AW);

  // R2
  a_r2_remap_base: assert property (@(posedge clk) disable iff (!rst_n)
    remapped_paged_in |=> (rom_sel && rom_addr[ROM_AW-1 -: SLOT_BANK_W]
                           == $past(slot_bank[pg_slot*SLOT_BANK_W +: SLOT_BANK_W])));

  a_r3_linear_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[23:22] == 2'b11) |=> rom_sel);

  a_r4_nmi_low: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_swap_en && cpu_addr == 24'h00FFEA) |=> (!rom_sel && ovr_data == $past(nmi_vec[7:0])));

  a_r5_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_swap_en && cpu_addr == 24'h00FFEF) |=> (!rom_sel && ovr_data == $past(irq_vec[15:8])));

  a_r6_mirror_fold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((32'(rom_addr) & ~size_mask(6'($past(rom_size_lg)))) == 32'd0));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_in |=> (!rom_sel && rom_addr == '0 && ovr_data == 8'h00));

  a_r8_sel_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (ovr_data == 8'h00));
endmodule

bind rom_slot_mapper rsm_checker #(.SLOT_BANK_W(SLOT_BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .slot_bank(slot_bank),
  .slot_remap(slot_remap), .nmi_swap_en(nmi_swap_en), .nmi_vec(nmi_vec),
  .irq_swap_en(irq_swap_en), .irq_vec(irq_vec), .rom_size_lg(rom_size_lg),
  .rom_sel(rom_sel), .rom_addr(rom_addr), .ovr_data(ovr_data)
);

// File: tb/tb_rom_slot_mapper.sv
module tb_rom_slot_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic [11:0] slot_bank;
  logic [3:0]  slot_remap;
  logic        nmi_swap_en, irq_swap_en;
  logic [15:0] nmi_vec, irq_vec;
  logic [4:0]  rom_size_lg;
  logic        rom_sel;
  logic [22:0] rom_addr;
  logic [7:0]  ovr_data;

  // configuration applied together with each address
  logic [11:0] c_bank  = {3'd7, 3'd5, 3'd2, 3'd6};
  logic [3:0]  c_remap = 4'b0000;
  logic        c_nmi_en = 1'b0, c_irq_en = 1'b0;
  logic [15:0] c_nmi = 16'hA55A, c_irq = 16'h3CC3;
  logic [4:0]  c_size = 5'd23;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        sel;
    logic [22:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  rom_slot_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .slot_bank(slot_bank),
    .slot_remap(slot_remap), .nmi_swap_en(nmi_swap_en), .nmi_vec(nmi_vec),
    .irq_swap_en(irq_swap_en), .irq_vec(irq_vec), .rom_size_lg(rom_size_lg),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .ovr_data(ovr_data)
  );

  function automatic exp_t model(input logic [23:0] a, input string tag);
    exp_t e;
    int bank, off, slot, base;
    longint phys;
    bank = int'(a[23:16]);
    off  = int'(a[15:0]);
    e.sel = 1'b0; e.addr = '0; e.data = 8'h00; e.tag = tag;
    phys = -1;
    if (c_nmi_en && a == 24'h00FFEA)      e.data = c_nmi[7:0];
    else if (c_nmi_en && a == 24'h00FFEB) e.data = c_nmi[15:8];
    else if (c_irq_en && a == 24'h00FFEE) e.data = c_irq[7:0];
    else if (c_irq_en && a == 24'h00FFEF) e.data = c_irq[15:8];
    else if (off >= 'h8000 && (bank <= 'h3F || (bank >= 'h80 && bank <= 'hBF))) begin
      if (bank < 'h20) slot = 0;
      else if (bank < 'h40) slot = 1;
      else if (bank < 'hA0) slot = 2;
      else slot = 3;
      base = c_remap[slot] ? int'(c_bank[slot*3 +: 3]) : slot;
      phys = longint'(base) * 1048576 + longint'(bank % 32) * 32768 + longint'(off - 'h8000);
    end else if (bank >= 'hC0) begin
      slot = (bank - 'hC0) / 16;
      base = int'(c_bank[slot*3 +: 3]);
      phys = longint'(base) * 1048576 + longint'(a[19:0]);
    end
    if (phys >= 0) begin
      if (c_size < 23) phys = phys % (longint'(1) << c_size);
      e.sel  = 1'b1;
      e.addr = 23'(phys);
    end
    return e;
  endfunction

  task automatic drive(input logic [23:0] a, input string tag);
    @(negedge clk);
    cpu_addr    = a;
    slot_bank   = c_bank;
    slot_remap  = c_remap;
    nmi_swap_en = c_nmi_en;
    irq_swap_en = c_irq_en;
    nmi_vec     = c_nmi;
    irq_vec     = c_irq;
    rom_size_lg = c_size;
    sb.push_back(model(a, tag));
  endtask

  // monitor: outputs for an address driven at a falling edge appear after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rom_sel !== e.sel || rom_addr !== e.addr || ovr_data !== e.data) begin
          errors++;
          $display("FAIL %s: got sel=%0b addr=%06h data=%02h, expected sel=%0b addr=%06h data=%02h",
                   e.tag, rom_sel, rom_addr, ovr_data, e.sel, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_addr = 24'h0; slot_bank = c_bank; slot_remap = c_remap;
    nmi_swap_en = 1'b0; irq_swap_en = 1'b0; nmi_vec = c_nmi; irq_vec = c_irq;
    rom_size_lg = c_size;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rom_sel !== 1'b0 || rom_addr !== 23'h0 || ovr_data !== 8'h00) begin
      errors++;
      $display("FAIL R8 reset: got sel=%0b addr=%06h data=%02h, expected 0/000000/00",
               rom_sel, rom_addr, ovr_data);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 fixed placement, one address per slot, back to back (R8 latency)
    drive(24'h008000, "R1 slot0 first");
    drive(24'h1FFFFF, "R1 slot0 last");
    drive(24'h259234, "R1 slot1");
    drive(24'h808000, "R1 slot2");
    drive(24'hA3C001, "R1 slot3 R8");
    // R2 remapped
    c_remap = 4'b1111;
    drive(24'h008000, "R2 slot0 remap");
    drive(24'h3F8001, "R2 slot1 remap");
    drive(24'h9ABCDE, "R2 slot2 remap");
    drive(24'hA3C001, "R2 slot3 remap");
    c_remap = 4'b0101;
    drive(24'h259234, "R2 slot1 fixed mixed");
    drive(24'h848000, "R2 slot2 remap mixed");
    // R3 linear view, flag ignored
    c_remap = 4'b0000;
    drive(24'hC00000, "R3 slot0 linear");
    drive(24'hDFABCD, "R3 slot1 linear");
    drive(24'hE51234, "R3 slot2 linear");
    drive(24'hFFFFFF, "R3 slot3 linear");
    c_remap = 4'b1111;
    drive(24'hDFABCD, "R3 linear remap set");
    // R4/R5 vector replacement
    c_remap = 4'b0000;
    c_nmi_en = 1'b1; c_irq_en = 1'b1;
    drive(24'h00FFEA, "R4 nmi low");
    drive(24'h00FFEB, "R4 nmi high");
    drive(24'h00FFEE, "R5 irq low");
    drive(24'h00FFEF, "R5 irq high");
    // R9 near misses
    drive(24'h00FFEC, "R9 FFEC");
    drive(24'h01FFEA, "R9 bank01");
    drive(24'h80FFEA, "R9 bank80");
    drive(24'h00FFE9, "R9 FFE9");
    // enables off, also with slot 0 remapped
    c_nmi_en = 1'b0; c_irq_en = 1'b0;
    drive(24'h00FFEA, "R4 nmi off");
    drive(24'h00FFEF, "R5 irq off");
    c_remap = 4'b0001;
    drive(24'h00FFEB, "R4 nmi off remap");
    drive(24'h00FFEE, "R5 irq off remap");
    c_nmi_en = 1'b1;
    drive(24'h00FFEE, "R5 irq off nmi on");
    drive(24'h00FFEB, "R4 nmi on remap");
    c_nmi_en = 1'b0;
    // R6 mirroring
    c_remap = 4'b0000;
    c_size = 5'd20;
    drive(24'hC12345, "R6 1MB linear");
    drive(24'hF8000F, "R6 1MB linear slot3");
    drive(24'h9F8001, "R6 1MB paged");
    c_size = 5'd17;
    drive(24'hE7FFFF, "R6 128KB");
    c_size = 5'd22;
    drive(24'hF00001, "R6 4MB");
    c_size = 5'd0;
    drive(24'hFFFFFF, "R6 1B");
    c_size = 5'd31;
    drive(24'hFFFFFF, "R6 oversize");
    c_size = 5'd23;
    // R7 unmapped
    drive(24'h000000, "R7 bank00 low");
    drive(24'h3F7FFF, "R7 bank3F low");
    drive(24'h408000, "R7 bank40");
    drive(24'h7FFFFF, "R7 bank7F");
    drive(24'hBF1234, "R7 bankBF low");
    drive(24'h00FFEA, "R8 after unmapped");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule